// File: doc/BRIEF.md
# Paged Free-Running Counter

The block is a 16-bit up counter behind a byte-wide register bus. It advances by one on every rising and every falling edge of a slow low-frequency clock input, which is about 1 kHz, so the count rate is about 2 kHz. Software controls the counter with a single control register. That register has a run/halt bit that can be read and written, a clear strobe that can only be written, and a page-select bit that can only be written.

While the page bit is 1, two bus offsets that normally reach two plain byte registers return the counter's high byte and low byte instead. Reading the high byte also copies the low byte into a shadow register. A later read of the low byte then returns that copy, so software always gets a matching 16-bit value. The slow clock is brought into the system clock domain through a two-flop synchronizer. The count advances one cycle after any change in the synchronized level. A 2-bit power-mode input is accepted, but it never stops the counter.

Top module: `paged_frc`

## Requirements
- R1: After synchronous reset, the counter is 0x0000, the run bit is 0, the page bit is 0, and both placeholder registers are 0x00.
- R2: While running, each change of `lf_clk` (rising or falling) adds exactly one to the count, about three system cycles after the change.
- R3: The count wraps from 0xFFFF to 0x0000 and keeps counting.
- R4: Writing control bit 5 as 0 freezes the count. Writing it as 1 resumes counting from the frozen value. Bit 5 reads back as written.
- R5: A control write with bit 7 set clears the count to 0x0000. If a slow edge arrives at the same time, 0x0001 is also acceptable. A write with bit 7 clear leaves the count unchanged. Bit 7 always reads 0.
- R6: With the page bit at 1 (control bit 0), offset 0x8 reads count[15:8] and offset 0x9 reads count[7:0], and writes to those offsets are ignored. With the page bit at 0, those offsets are two read/write byte registers.
- R7: Writing the page bit back to 0 does not change the run/halt state. The page bit always reads 0.
- R8: The `pmode` input (0 run, 1–3 stop levels) has no effect on counting.
- R9: The control register is at offset 0xB. Its bits 7:6 and 4:0 read 0, and writes to bits 6 and 4:1 have no effect. All other offsets read 0x00.
- R10: With the page bit at 1, a read at 0x8 captures count[7:0]. The next read at 0x9 returns that captured byte even if the count has moved. Without a pending capture, 0x9 returns the live low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_clk | input | 1 | Slow clock; both of its edges advance the count |
| pmode | input | 2 | Power mode (has no effect on counting) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, one cycle |
| re | input | 1 | Read strobe (arms the shadow capture) |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The count is driven with slow-clock bursts of different lengths, including a long run of one toggle per cycle that reaches 0xFFFF and wraps. This shows whether rising and falling edges are counted the same way and whether the wrap behaves correctly. The bench mixes random control bytes, pages, placeholder writes, mode changes and reads. From these it can tell a frozen count apart from a running one, a real clear apart from a write with bit 7 at 0, and counter bytes apart from placeholder bytes. Reading the high byte, then moving the count, then reading the low byte tells the shadow byte apart from the live byte.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_HI   = 4'h8;
    localparam logic [ADDR_W-1:0] A_LO   = 4'h9;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'hB;

    localparam int B_CLR  = 7;
    localparam int B_RUN  = 5;
    localparam int B_PAGE = 0;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_STOP4 = 2'd1,
        PM_STOP3 = 2'd2,
        PM_STOP1 = 2'd3
    } pmode_e;

    typedef struct packed {
        logic run;
        logic page;
    } ctrl_t;

    // Every mode keeps the counter alive once it is enabled.
    function automatic logic mode_counts(input logic [1:0] m);
        case (pmode_e'(m))
            PM_RUN, PM_STOP4, PM_STOP3, PM_STOP1: return 1'b1;
            default:                              return 1'b1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_RUN] = c.run;
        return v;
    endfunction
endpackage

// File: rtl/frc_edge_sync.sv
module frc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic tick
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign tick = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/frc_counter.sv
module frc_counter
    import frc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [1:0]       pmode,
    output logic [CNT_W-1:0] count
);
    logic step;
    assign step = run & tick & mode_counts(pmode);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (clr)  count <= '0;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/frc_regbank.sv
module frc_regbank
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic              clr
);
    logic [DATA_W-1:0] hold_a, hold_b, shadow;
    logic              armed;
    logic              wr_ctrl, wr_a, wr_b;

    assign wr_ctrl = we && (addr == A_CTRL);
    assign wr_a    = we && (addr == A_HI) && !ctrl.page;
    assign wr_b    = we && (addr == A_LO) && !ctrl.page;
    assign clr     = wr_ctrl && wdata[B_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            hold_a <= '0;
            hold_b <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run  <= wdata[B_RUN];
                ctrl.page <= wdata[B_PAGE];
            end
            if (wr_a) hold_a <= wdata;
            if (wr_b) hold_b <= wdata;
        end
    end

    // Coherent pair read: the high-byte read snapshots the low byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            armed  <= 1'b0;
        end else if (re && ctrl.page) begin
            if (addr == A_HI) begin
                shadow <= count[DATA_W-1:0];
                armed  <= 1'b1;
            end else if (addr == A_LO) begin
                armed  <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_HI:    rdata = ctrl.page ? count[CNT_W-1:DATA_W] : hold_a;
            A_LO:    rdata = ctrl.page ? (armed ? shadow : count[DATA_W-1:0]) : hold_b;
            A_CTRL:  rdata = ctrl_image(ctrl);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/paged_frc.sv
module paged_frc
    import frc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lf_clk,
    input  logic [1:0]        pmode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata
);
    logic             tick;
    logic             clr_pulse;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt_q;

    frc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(lf_clk), .tick(tick)
    );

    frc_counter u_cnt (
        .clk(clk), .rst(rst), .clr(clr_pulse), .run(ctrl.run),
        .tick(tick), .pmode(pmode), .count(cnt_q)
    );

    frc_regbank u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .count(cnt_q), .rdata(rdata), .ctrl(ctrl), .clr(clr_pulse)
    );
endmodule

// File: rtl/frc_checker.sv
module frc_checker
    import frc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run,
    input logic              page,
    input logic              clr_pulse
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt_q == '0 && !run && !page));

    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr_pulse) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + 1'b1);

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(clr_pulse)) |-> $stable(cnt_q));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $past(clr_pulse) |-> cnt_q <= 16'd1);

    p_hi_byte_r6: assert property (@(posedge clk) disable iff (rst)
        (page && addr == A_HI) |-> rdata == cnt_q[CNT_W-1:DATA_W]);

    p_ctrl_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTRL) |-> (rdata[7:6] == 2'b00 && rdata[4:0] == 5'b0));
endmodule

bind paged_frc frc_checker u_chk (
    .clk(clk), .rst(rst), .addr(addr), .rdata(rdata), .cnt_q(cnt_q),
    .run(ctrl.run), .page(ctrl.page), .clr_pulse(clr_pulse)
);

// File: tb/tb_paged_frc.sv
module tb_paged_frc;
    logic       clk = 0, rst = 1, lf_clk = 0, we = 0, re = 0;
    logic [1:0] pmode = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0, rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [15:0] m_cnt = 0;
    logic        m_run = 0, m_page = 0, m_armed = 0;
    logic [7:0]  m_a = 0, m_b = 0, m_shadow = 0;

    paged_frc dut (.clk(clk), .rst(rst), .lf_clk(lf_clk), .pmode(pmode),
                   .addr(addr), .wdata(wdata), .we(we), .re(re), .rdata(rdata));

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'h8: return m_page ? m_cnt[15:8] : m_a;
            4'h9: return m_page ? (m_armed ? m_shadow : m_cnt[7:0]) : m_b;
            4'hB: return {2'b00, m_run, 5'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // tasks start and end just after a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1;
        @(negedge clk);
        we = 0;
        if (a == 4'hB) begin
            m_run = d[5]; m_page = d[0];
            if (d[7]) m_cnt = 0;
        end else if (a == 4'h8 && !m_page) m_a = d;
        else if (a == 4'h9 && !m_page) m_b = d;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] got);
        addr = a; re = 1; #1;
        got = rdata;
        @(negedge clk);
        re = 0;
        if (m_page && a == 4'h8) begin m_shadow = m_cnt[7:0]; m_armed = 1; end
        else if (m_page && a == 4'h9) m_armed = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a);
        logic [7:0] e, g;
        e = exp_read(a);
        rd(a, g);
        check(tag, {8'h0, g}, {8'h0, e});
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            lf_clk = ~lf_clk;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        if (m_run) m_cnt = m_cnt + 16'(n);
    endtask

    task automatic rd_count(output logic [15:0] v);
        logic [7:0] h, l;
        rd(4'h8, h);
        rd(4'h9, l);
        v = {h, l};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  g;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 hold_a", 4'h8);
        rd_chk("R1 hold_b", 4'h9);
        rd_chk("R1 ctrl", 4'hB);
        wr(4'hB, 8'h01);
        rd_count(v); check("R1 count", v, 16'h0000);

        // R2 both edges counted
        wr(4'hB, 8'h21);
        burst(5);
        rd_count(v); check("R2 five edges", v, m_cnt);
        burst(1);
        rd_count(v); check("R2 single edge", v, 16'h0006);

        // R4 halt and resume
        wr(4'hB, 8'h01);
        burst(7);
        rd_count(v); check("R4 halted", v, 16'h0006);
        wr(4'hB, 8'h21);
        burst(3);
        rd_count(v); check("R4 resumed", v, 16'h0009);

        // R5 bit7 clear: write 0 no effect, reads 0
        wr(4'hB, 8'h21);
        rd_count(v); check("R5 no clear", v, 16'h0009);
        rd_chk("R5 ctrl reads", 4'hB);
        wr(4'hB, 8'hA1);
        rd_count(v); check("R5 clear", v, 16'h0000);

        // R9 reserved bits ignore writes
        wr(4'hB, 8'h7F);
        rd_chk("R9 reserved", 4'hB);
        rd_chk("R9 other addr", 4'h3);

        // R7 page back to 0 keeps running, page bit reads 0
        wr(4'hB, 8'h20);
        burst(4);
        wr(4'hB, 8'h21);
        rd_count(v); check("R7 still running", v, m_cnt);

        // R8 mode has no effect
        pmode = 2'd3;
        burst(6);
        rd_count(v); check("R8 stop mode counts", v, m_cnt);
        pmode = 2'd0;

        // R6 writes to counter bytes ignored while paged
        wr(4'h8, 8'h5A);
        rd_count(v); check("R6 paged write ignored", v, m_cnt);
        wr(4'hB, 8'h20);
        wr(4'h8, 8'hC3);
        wr(4'h9, 8'h3C);
        rd_chk("R6 placeholder a", 4'h8);
        rd_chk("R6 placeholder b", 4'h9);
        wr(4'hB, 8'h21);

        // R10 shadow coherence
        rd(4'h8, g);
        burst(9);
        rd_chk("R10 shadow low", 4'h9);
        rd_chk("R10 live low", 4'h9);

        // R3 wrap
        wr(4'hB, 8'hA1);
        burst(65535);
        rd_count(v); check("R3 at max", v, 16'hFFFF);
        burst(2);
        rd_count(v); check("R3 wrapped", v, 16'h0001);

        // R5 clear close to a slow edge: 0 or 1 accepted
        lf_clk = ~lf_clk;
        wr(4'hB, 8'hA1);
        repeat (4) @(negedge clk);
        rd_count(v);
        checks++;
        if (v > 16'd1) begin
            errors++;
            $display("FAIL R5 clear near edge: got %h expected 0000 or 0001", v);
        end
        m_cnt = v;

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: burst($urandom_range(1, 20));
                1: begin
                    logic [7:0] d;
                    d = 8'($urandom());
                    wr(4'hB, d);
                end
                2: wr($urandom_range(0, 1) ? 4'h8 : 4'h9, 8'($urandom()));
                3: rd_chk("R6 random read", 4'($urandom()));
                default: pmode = 2'($urandom());
            endcase
        end
        wr(4'hB, 8'h01);
        rd_count(v); check("R2 random final", v, m_cnt);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule